// File: doc/BRIEF.md
# Page Write Collector With Load Timeout

This block sits between a byte-wide host write port and a page-organised non-volatile array. The host sends single-byte writes. Each write carries an 11-bit address and a data byte. The first write starts a page load. Every byte that belongs to the load goes into a 64-entry page buffer, and a per-byte enable mask records which offsets were written. An inactivity timer restarts on every accepted byte. When no byte has arrived for the programmed number of cycles, the load ends. No explicit "go" command is used.

At the end of a load, the collector checks the page field of every byte it took. If they all agree, it raises a one-cycle commit request that carries the page number, the byte-enable mask and a flat copy of the buffer. A modelled internal write phase of fixed length then begins. If any byte named a different page, the whole load is thrown away and no write phase follows. A status flag shows that the timer has expired and the write phase is running. A ready flag is low from the first accepted byte until the write phase, or the abort, is over. Host strobes that arrive during the write phase are dropped silently.

Top module: `page_collector`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `ready` is 1, `load_expired` is 0 and `commit_valid` is 0.
- R2: A strobe sampled while the block is idle starts a page load: from the next cycle `ready` is 0 and `load_expired` stays 0 for the whole load.
- R3: Address bits [10:6] give the page and bits [5:0] give the byte offset k. In a commit, `commit_page` is the page, bit k of `commit_mask` is 1 exactly for the offsets written, and `commit_data[8k+7:8k]` holds the last byte written to offset k.
- R4: With the last accepted strobe sampled at clock edge c, `commit_valid` is 1 in the cycle after edge c+TIMEOUT_CYC. A strobe sampled at that same edge restarts the timer instead of ending the load.
- R5: `load_expired` is 1 for exactly WRITE_CYC cycles, starting with the commit cycle. `ready` stays 0 during that time. After the write phase, `ready` returns to 1 and `load_expired` to 0.
- R6: If any byte of a load carries page bits that differ from those of the first byte, the load ends at the same timeout without a commit. `load_expired` stays 0, and `ready` returns to 1 in the cycle where the commit would have appeared.
- R7: Strobes sampled while `load_expired` is 1 are ignored. They start no load, change no mask or data, and do not lengthen the write phase.
- R8: The byte-enable mask is cleared after every commit or abort, so a later commit shows only the offsets written in its own load.
- R9: `commit_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One byte write, sampled on each rising edge |
| wr_addr | input | 11 | Page (bits 10:6) and byte offset (bits 5:0) |
| wr_data | input | 8 | Byte to write |
| commit_valid | output | 1 | One-cycle commit request |
| commit_page | output | 5 | Page of the committed load |
| commit_mask | output | 64 | One bit per byte offset written |
| commit_data | output | 512 | Buffer contents, byte k at bits 8k+7:8k |
| load_expired | output | 1 | High while the internal write phase runs |
| ready | output | 1 | Low from the first accepted byte until the write or abort ends |

## Verification
The assertions assume that `rst` is held high from time zero through at least one rising edge. They also assume that `wr_stb`, `wr_addr` and `wr_data` are synchronous and free of X whenever `rst` is low. The bench drives every input only on falling edges, raises the strobe for one cycle per byte, and releases reset only after several edges. The timeout and write lengths are cut to short values, so the timer boundary, a strobe that lands exactly on the expiry edge, page mismatches and strobes during the write phase all occur within a short run.

// File: rtl/pgcol_pkg.sv
package pgcol_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOAD  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/pc_load_timer.sv
// Inactivity timer: counts cycles since the last accepted byte.
module pc_load_timer #(
  parameter int TIMEOUT_CYC = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (run && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && !restart && (cnt_q == LAST);
endmodule

// File: rtl/pc_write_phase.sv
// Fixed-length model of the internal write phase.
module pc_write_phase #(
  parameter int WRITE_CYC = 600000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int WW = $clog2(WRITE_CYC + 1);
  localparam logic [WW-1:0] LAST = WW'(WRITE_CYC - 1);

  logic [WW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == LAST) act_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = act_q && (cnt_q == LAST);
endmodule

// File: rtl/pc_page_buffer.sv
// Page storage with byte-enable mask and a registered snapshot for commit.
module pc_page_buffer #(
  parameter int OFFS_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [OFFS_W-1:0]             offs,
  input  logic [DATA_W-1:0]             din,
  input  logic                          clear,
  input  logic                          snap,
  output logic [(1<<OFFS_W)-1:0]        snap_mask,
  output logic [(1<<OFFS_W)*DATA_W-1:0] snap_data
);
  localparam int BYTES = 1 << OFFS_W;

  logic [DATA_W-1:0] mem [BYTES];
  logic [BYTES-1:0]  mask_q;

  always_ff @(posedge clk) begin
    if (we) mem[offs] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else begin
      if (clear) mask_q <= '0;
      if (we) mask_q[offs] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) snap_mask <= '0;
    else if (snap) snap_mask <= mask_q;
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_snap
    always_ff @(posedge clk) begin
      if (rst) snap_data[k*DATA_W +: DATA_W] <= '0;
      else if (snap) snap_data[k*DATA_W +: DATA_W] <= mem[k];
    end
  end
endmodule

// File: rtl/page_collector.sv
module page_collector #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int OFFS_W      = 6,
  parameter int TIMEOUT_CYC = 20000,
  parameter int WRITE_CYC   = 600000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_stb,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic                          commit_valid,
  output logic [ADDR_W-OFFS_W-1:0]      commit_page,
  output logic [(1<<OFFS_W)-1:0]        commit_mask,
  output logic [(1<<OFFS_W)*DATA_W-1:0] commit_data,
  output logic                          load_expired,
  output logic                          ready
);
  import pgcol_pkg::*;

  localparam int PAGE_W = ADDR_W - OFFS_W;

  phase_e            phase_q;
  logic [PAGE_W-1:0] page_q;
  logic              bad_q;
  logic              accept, expire, wdone, good_end;
  logic [PAGE_W-1:0] in_page;

  assign in_page  = wr_addr[ADDR_W-1:OFFS_W];
  assign accept   = wr_stb && (phase_q != PH_WRITE);
  assign good_end = expire && !bad_q;

  pc_load_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst),
    .run(phase_q == PH_LOAD), .restart(accept),
    .expire(expire)
  );

  pc_write_phase #(.WRITE_CYC(WRITE_CYC)) u_wph (
    .clk(clk), .rst(rst), .start(good_end), .done(wdone)
  );

  pc_page_buffer #(.OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst),
    .we(accept), .offs(wr_addr[OFFS_W-1:0]), .din(wr_data),
    .clear(expire), .snap(good_end),
    .snap_mask(commit_mask), .snap_data(commit_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_IDLE;
      page_q       <= '0;
      bad_q        <= 1'b0;
      commit_valid <= 1'b0;
      commit_page  <= '0;
      load_expired <= 1'b0;
      ready        <= 1'b1;
    end else begin
      commit_valid <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (wr_stb) begin
            page_q  <= in_page;
            bad_q   <= 1'b0;
            ready   <= 1'b0;
            phase_q <= PH_LOAD;
          end
        end
        PH_LOAD: begin
          if (wr_stb) begin
            if (in_page != page_q) bad_q <= 1'b1;
          end else if (expire) begin
            if (bad_q) begin
              ready   <= 1'b1;
              phase_q <= PH_IDLE;
            end else begin
              commit_valid <= 1'b1;
              commit_page  <= page_q;
              load_expired <= 1'b1;
              phase_q      <= PH_WRITE;
            end
          end
        end
        PH_WRITE: begin
          if (wdone) begin
            load_expired <= 1'b0;
            ready        <= 1'b1;
            phase_q      <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
  parameter int PAGE_W = 5,
  parameter int BYTES  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic              commit_valid,
  input logic [BYTES-1:0]  commit_mask,
  input logic              load_expired,
  input logic              ready
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    commit_valid |=> !commit_valid);

  a_r5_commit_starts_write: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> (load_expired && !ready));

  a_r5_busy_while_writing: assert property (@(posedge clk) disable iff (rst)
    load_expired |-> !ready);

  a_r5_write_begins_with_commit: assert property (@(posedge clk) disable iff (rst)
    $rose(load_expired) |-> commit_valid);

  a_r5_mask_held_in_write: assert property (@(posedge clk) disable iff (rst)
    (load_expired && $past(load_expired)) |-> $stable(commit_mask));

  a_r2_ready_falls_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(wr_stb));

  a_r7_write_ignores_strobe: assert property (@(posedge clk) disable iff (rst)
    (load_expired && wr_stb) |=> (ready || load_expired));

  a_r3_mask_nonempty: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> (commit_mask != '0));
endmodule

bind page_collector pc_checker #(
  .PAGE_W(ADDR_W - OFFS_W), .BYTES(1 << OFFS_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb),
  .commit_valid(commit_valid), .commit_mask(commit_mask),
  .load_expired(load_expired), .ready(ready)
);

// File: tb/sim_page_collector.sv
`timescale 1ns/1ps
module sim_page_collector;
  localparam int T = 12;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_stb = 1'b0;
  logic [10:0]  wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic         commit_valid, load_expired, ready;
  logic [4:0]   commit_page;
  logic [63:0]  commit_mask;
  logic [511:0] commit_data;

  page_collector #(.TIMEOUT_CYC(T), .WRITE_CYC(W)) u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_valid(commit_valid), .commit_page(commit_page),
    .commit_mask(commit_mask), .commit_data(commit_data),
    .load_expired(load_expired), .ready(ready)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, n_commit = 0;
  logic [63:0] last_mask;

  // Behavioural reference: phase 0 idle, 1 loading, 2 writing; times as cycle stamps.
  int          m_ph = 0, m_last = 0, m_wstart = 0;
  logic [4:0]  m_page;
  logic        m_bad;
  logic [63:0] m_mask;
  logic [511:0] m_data;
  logic        e_ready = 1'b1, e_exp = 1'b0, e_cv = 1'b0;
  logic [4:0]  e_page;
  logic [63:0] e_mask;
  logic [511:0] e_data;

  always @(posedge clk) begin
    cyc++;
    e_cv = 1'b0;
    if (rst) begin
      m_ph = 0; e_ready = 1'b1; e_exp = 1'b0;
    end else if (m_ph == 0) begin
      if (wr_stb) begin
        m_ph = 1; m_last = cyc; m_page = wr_addr[10:6]; m_bad = 1'b0;
        m_mask = '0; m_mask[wr_addr[5:0]] = 1'b1;
        m_data[int'(wr_addr[5:0])*8 +: 8] = wr_data;
        e_ready = 1'b0;
      end
    end else if (m_ph == 1) begin
      if (wr_stb) begin
        m_last = cyc;
        if (wr_addr[10:6] != m_page) m_bad = 1'b1;
        m_mask[wr_addr[5:0]] = 1'b1;
        m_data[int'(wr_addr[5:0])*8 +: 8] = wr_data;
      end else if (cyc - m_last == T) begin
        if (m_bad) begin
          m_ph = 0; e_ready = 1'b1;
        end else begin
          m_ph = 2; m_wstart = cyc; e_cv = 1'b1; e_exp = 1'b1;
          e_page = m_page; e_mask = m_mask; e_data = m_data;
        end
      end
    end else begin
      if (cyc - m_wstart == W) begin
        m_ph = 0; e_exp = 1'b0; e_ready = 1'b1;
      end
    end
  end

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R5 ready", 512'(ready), 512'(e_ready));
      chk("R5 load_expired", 512'(load_expired), 512'(e_exp));
      chk("R4 R6 R9 commit_valid", 512'(commit_valid), 512'(e_cv));
      if (e_cv) begin
        chk("R3 commit_page", 512'(commit_page), 512'(e_page));
        chk("R3 R8 commit_mask", 512'(commit_mask), 512'(e_mask));
        chk("R3 commit_data", commit_data, e_data);
      end
      if (commit_valid) begin
        n_commit++;
        last_mask = commit_mask;
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
    finish_run();
  end

  // Called at a falling edge; strobe is sampled at the next rising edge.
  task automatic wbyte(input logic [4:0] pg, input logic [5:0] off, input logic [7:0] d);
    wr_stb = 1'b1; wr_addr = {pg, off}; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    @(negedge clk);
    // R1: reset values
    idle(3);
    chk("R1 ready in reset", 512'(ready), 512'(1));
    chk("R1 load_expired in reset", 512'(load_expired), 512'(0));
    chk("R1 commit_valid in reset", 512'(commit_valid), 512'(0));
    rst = 1'b0;
    idle(2);

    // Single byte
    wbyte(5'd3, 6'd5, 8'hA7);
    chk("R2 ready low after first byte", 512'(ready), 512'(0));
    idle(T + W + 4);
    chk("R4 one commit for single byte", 512'(n_commit), 512'(1));

    // Full page with varying gaps below the timeout
    for (int i = 0; i < 64; i++) begin
      wbyte(5'h1F, 6'(i), 8'(i * 3 + 1));
      idle(i % (T - 1));
    end
    idle(T + W + 4);
    chk("R3 full page committed once", 512'(n_commit), 512'(2));
    chk("R3 full page mask", 512'(last_mask), 512'({64{1'b1}}));

    // Same offset twice: latest byte wins; mask cleared after previous commit
    wbyte(5'd9, 6'd63, 8'h11);
    idle(2);
    wbyte(5'd9, 6'd63, 8'h22);
    idle(T + W + 4);
    chk("R8 mask only new offset", 512'($countones(last_mask)), 512'(1));
    chk("R8 committed count", 512'(n_commit), 512'(3));

    // Page mismatch aborts
    base = n_commit;
    wbyte(5'd4, 6'd0, 8'h01);
    wbyte(5'd4, 6'd1, 8'h02);
    wbyte(5'd5, 6'd2, 8'h03);
    idle(T + 1);
    chk("R6 ready back after abort", 512'(ready), 512'(1));
    chk("R6 no write phase after abort", 512'(load_expired), 512'(0));
    idle(W);
    chk("R6 no commit after abort", 512'(n_commit - base), 512'(0));

    // Gap of exactly T-1 idle cycles: strobe lands on the expiry edge and extends the load
    base = n_commit;
    wbyte(5'd7, 6'd10, 8'h5A);
    idle(T - 1);
    wbyte(5'd7, 6'd11, 8'hC3);
    idle(T + W + 4);
    chk("R4 boundary strobe merges into one commit", 512'(n_commit - base), 512'(1));
    chk("R4 boundary mask has both bytes", 512'($countones(last_mask)), 512'(2));

    // Strobes during the write phase are ignored
    base = n_commit;
    wbyte(5'd2, 6'd1, 8'h99);
    idle(T + 2);
    for (int i = 0; i < 5; i++) wbyte(5'd6, 6'(i), 8'(i));
    idle(2);
    chk("R7 still writing after ignored strobes", 512'(load_expired), 512'(1));
    idle(W);
    chk("R7 ready after write despite strobes", 512'(ready), 512'(1));
    chk("R7 one commit only", 512'(n_commit - base), 512'(1));

    // Immediate new load after a write ends
    wbyte(5'd0, 6'd0, 8'hFE);
    idle(T + W + 4);
    chk("R8 new load after write", 512'(last_mask), 512'(64'h1));
    chk("R9 total commits", 512'(n_commit), 512'(base + 2));
    finish_run();
  end
endmodule